// File: doc/BRIEF.md
# Fractional Output Divider with Triangle Spread

The block turns a fast reference-domain clock into a slower output by emitting a one-cycle enable pulse, `tick_o`, at the end of every output period. The division ratio is a fixed-point number with a 12-bit whole part and a 24-bit fraction. Each period adds the fraction to a running 24-bit remainder, and every overflow of that remainder makes the period one input cycle longer. Over many periods the average ratio therefore equals the programmed value exactly.

Three alternatives to plain fractional division are available. A whole-number mode drops the fraction. A pass-through mode makes every input cycle an output period. A spread generator adds a triangle-shaped offset to the fraction, which lowers and raises the output frequency at a slow programmable rate. The divider stays idle until the first `sync_i` pulse. That same pulse restarts the divider at any later time. Several copies fed from one `sync_i` start on the same input cycle, so copies running whole-number ratios stay in phase from then on.

All ratio, mode and spread inputs are sampled only on the input cycle that closes a period, or on a sync cycle. The divider reads nothing from them at any other time.

Top module: `fod_divider`

## Requirements
- R1: In fractional mode each period lasts W + C input cycles. W is `div_int_i`, and C is the carry out of the 24-bit sum of the remainder, `div_frac_i` and the spread offset. The low 24 bits of that sum become the new remainder.
- R2: With `int_only_i`=1 and `bypass_i`=0 each period lasts exactly W cycles. The fraction and the spread offset have no effect, and the remainder is held.
- R3: With `bypass_i`=1 the period is one cycle, so `tick_o` is high on every cycle. This overrides `int_only_i`, the fraction and spread, and the remainder is held.
- R4: A whole part of 0 is treated as 1.
- R5: A `sync_i` cycle clears the remainder and the spread state and starts a new period at once, using the current inputs. In fractional mode the first period after sync is exactly W cycles long.
- R6: Instances that share `sync_i` and run whole-number ratios, where one ratio is a multiple of the other, produce coincident ticks at every tick of the slower instance.
- R7: Inputs that change inside a period do not alter that period. The remainder and the spread offset change only on a boundary cycle or a sync cycle.
- R8: With `ssc_en_i`=1 the boundary counter reaches its trigger point every `ssc_hold_i` periods, and a value of 0 counts as 1. At each trigger the offset climbs by `ssc_step_i` until the sum would reach `ssc_lim_i`, where it clamps to `ssc_lim_i` and turns downward. Moving down, the offset falls by the step until it would reach 0 or less, where it clamps to 0 and turns upward. Each boundary uses the offset value from before that boundary's update.
- R9: A boundary with `ssc_en_i`=0 clears the offset, the direction and the hold counter.
- R10: `tick_o` is low during reset and stays low until the first `sync_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast input clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sync_i | input | 1 | Shared start and realign pulse |
| div_int_i | input | 12 | Whole part of the ratio |
| div_frac_i | input | 24 | Fractional part of the ratio, in units of 2^-24 |
| int_only_i | input | 1 | Whole-number mode |
| bypass_i | input | 1 | Divide-by-1 pass-through |
| ssc_en_i | input | 1 | Spread modulation enable |
| ssc_step_i | input | 24 | Offset change per trigger |
| ssc_lim_i | input | 24 | Upper clamp of the offset |
| ssc_hold_i | input | 16 | Periods between offset triggers |
| tick_o | output | 1 | One-cycle pulse closing each output period |

## Verification
Several properties are checked on every cycle by the assertions. The remainder and the spread offset hold steady between boundaries. Sync starts the divider with the expected remainder. Pass-through keeps `tick_o` high, and whole-number mode freezes the remainder. An upward spread step never passes the limit, and a downward step never raises the offset. Checking the exact length of every period needs the scenarios in the bench. That covers the carry pattern of a fraction, the shape of the triangle and its timing, the sampling of inputs only at a boundary, and the phase match between two instances. For these the bench replays the rules above and measures the spacing between ticks.

// File: rtl/fod_pkg.sv
package fod_pkg;
  localparam int unsigned DIV_INT_W  = 12;
  localparam int unsigned DIV_FRAC_W = 24;
  localparam int unsigned SSC_HOLD_W = 16;

  typedef struct packed {
    logic bypass;
    logic int_only;
    logic ssc_en;
  } fod_mode_t;
endpackage

// File: rtl/fod_phase.sv
module fod_phase #(
  parameter int unsigned INT_W  = fod_pkg::DIV_INT_W,
  parameter int unsigned FRAC_W = fod_pkg::DIV_FRAC_W,
  localparam int unsigned LEN_W = INT_W + 1,
  localparam int unsigned SUM_W = FRAC_W + 2
) (
  input  logic [FRAC_W-1:0] acc_i,
  input  logic [FRAC_W-1:0] off_i,
  input  logic [INT_W-1:0]  int_i,
  input  logic [FRAC_W-1:0] frac_i,
  input  fod_pkg::fod_mode_t mode_i,
  output logic [LEN_W-1:0]  len_o,
  output logic [FRAC_W-1:0] acc_o
);
  logic [LEN_W-1:0] whole;
  logic [SUM_W-1:0] total;

  always_comb begin
    whole = (int_i == '0) ? LEN_W'(1) : {1'b0, int_i};
    total = {2'b00, acc_i} + {2'b00, frac_i}
          + (mode_i.ssc_en ? {2'b00, off_i} : SUM_W'(0));
    if (mode_i.bypass) begin
      len_o = LEN_W'(1);
      acc_o = acc_i;
    end else if (mode_i.int_only) begin
      len_o = whole;
      acc_o = acc_i;
    end else begin
      // carry out of the fraction stretches the period
      len_o = whole + LEN_W'(total[SUM_W-1:FRAC_W]);
      acc_o = total[FRAC_W-1:0];
    end
  end
endmodule

// File: rtl/fod_ssc.sv
module fod_ssc #(
  parameter int unsigned FRAC_W = fod_pkg::DIV_FRAC_W,
  parameter int unsigned HOLD_W = fod_pkg::SSC_HOLD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sync_i,
  input  logic              bound_i,
  input  logic              en_i,
  input  logic [FRAC_W-1:0] step_i,
  input  logic [FRAC_W-1:0] lim_i,
  input  logic [HOLD_W-1:0] hold_i,
  output logic [FRAC_W-1:0] off_o
);
  logic [FRAC_W-1:0] off_q;
  logic              dn_q;
  logic [HOLD_W-1:0] hc_q;
  logic [HOLD_W-1:0] hold_last;
  logic [FRAC_W:0]   up_sum;
  logic              step_now;

  assign hold_last = (hold_i == '0) ? '0 : hold_i - HOLD_W'(1);
  assign step_now  = (hc_q >= hold_last);
  assign up_sum    = {1'b0, off_q} + {1'b0, step_i};
  assign off_o     = off_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      off_q <= '0;
      dn_q  <= 1'b0;
      hc_q  <= '0;
    end else if (sync_i || (bound_i && !en_i)) begin
      off_q <= '0;
      dn_q  <= 1'b0;
      hc_q  <= '0;
    end else if (bound_i) begin
      if (step_now) begin
        hc_q <= '0;
        if (!dn_q) begin
          if (up_sum >= {1'b0, lim_i}) begin
            off_q <= lim_i;
            dn_q  <= 1'b1;
          end else begin
            off_q <= up_sum[FRAC_W-1:0];
          end
        end else if (off_q <= step_i) begin
          off_q <= '0;
          dn_q  <= 1'b0;
        end else begin
          off_q <= off_q - step_i;
        end
      end else begin
        hc_q <= hc_q + HOLD_W'(1);
      end
    end
  end

  assert_off_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sync_i && !bound_i) |=> $stable(off_q));

  assert_off_ceiling_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bound_i && en_i && !sync_i && step_now && !dn_q) |=> (off_q <= $past(lim_i)));

  assert_off_falling_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bound_i && en_i && !sync_i && step_now && dn_q) |=> (off_q <= $past(off_q)));
endmodule

// File: rtl/fod_count.sv
module fod_count #(
  parameter int unsigned LEN_W = fod_pkg::DIV_INT_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             zero_o
);
  logic [LEN_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= len_i - LEN_W'(1);
    else if (cnt_q != '0)    cnt_q <= cnt_q - LEN_W'(1);
  end

  assign zero_o = (cnt_q == '0);

  assert_len_nonzero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> (len_i != '0));
endmodule

// File: rtl/fod_divider.sv
module fod_divider #(
  parameter int unsigned INT_W  = fod_pkg::DIV_INT_W,
  parameter int unsigned FRAC_W = fod_pkg::DIV_FRAC_W,
  parameter int unsigned HOLD_W = fod_pkg::SSC_HOLD_W,
  localparam int unsigned LEN_W = INT_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sync_i,
  input  logic [INT_W-1:0]  div_int_i,
  input  logic [FRAC_W-1:0] div_frac_i,
  input  logic              int_only_i,
  input  logic              bypass_i,
  input  logic              ssc_en_i,
  input  logic [FRAC_W-1:0] ssc_step_i,
  input  logic [FRAC_W-1:0] ssc_lim_i,
  input  logic [HOLD_W-1:0] ssc_hold_i,
  output logic              tick_o
);
  fod_pkg::fod_mode_t mode;
  logic              run_q;
  logic [FRAC_W-1:0] acc_q, acc_base, acc_nxt, off, off_base;
  logic [LEN_W-1:0]  len;
  logic              zero, load;

  assign mode     = '{bypass: bypass_i, int_only: int_only_i, ssc_en: ssc_en_i};
  assign tick_o   = run_q & zero;
  assign load     = sync_i | tick_o;
  assign acc_base = sync_i ? '0 : acc_q;
  assign off_base = sync_i ? '0 : off;

  fod_phase #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_phase (
    .acc_i  (acc_base),
    .off_i  (off_base),
    .int_i  (div_int_i),
    .frac_i (div_frac_i),
    .mode_i (mode),
    .len_o  (len),
    .acc_o  (acc_nxt)
  );

  fod_ssc #(.FRAC_W(FRAC_W), .HOLD_W(HOLD_W)) u_ssc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sync_i  (sync_i),
    .bound_i (tick_o),
    .en_i    (ssc_en_i),
    .step_i  (ssc_step_i),
    .lim_i   (ssc_lim_i),
    .hold_i  (ssc_hold_i),
    .off_o   (off)
  );

  fod_count #(.LEN_W(LEN_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .len_i  (len),
    .zero_o (zero)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      acc_q <= '0;
    end else begin
      if (sync_i) run_q <= 1'b1;
      if (load)   acc_q <= acc_nxt;
    end
  end

  assert_start_on_sync_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_q) |-> $past(sync_i));

  assert_sync_restart_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_i |=> (run_q && acc_q == (($past(bypass_i) || $past(int_only_i)) ? '0 : $past(div_frac_i))));

  assert_bypass_every_cycle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((tick_o || sync_i) && bypass_i) |=> tick_o);

  assert_int_only_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && !sync_i && int_only_i && !bypass_i) |=> $stable(acc_q));

  assert_acc_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_o && !sync_i) |=> $stable(acc_q));
endmodule

// File: tb/tb_fod_divider.sv
module tb_fod_divider;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sync_p = 1'b0;
  logic [11:0] dint = '0;
  logic [23:0] dfrac = '0;
  logic        iono = 1'b0, byp = 1'b0, sen = 1'b0;
  logic [23:0] sstep = '0, slim = '0;
  logic [15:0] shold = '0;
  logic        tick, tick_b;

  always #4 clk = ~clk;

  fod_divider dut (
    .clk_i(clk), .rst_ni(rst_n), .sync_i(sync_p), .div_int_i(dint), .div_frac_i(dfrac),
    .int_only_i(iono), .bypass_i(byp), .ssc_en_i(sen), .ssc_step_i(sstep),
    .ssc_lim_i(slim), .ssc_hold_i(shold), .tick_o(tick));

  fod_divider dut_b (
    .clk_i(clk), .rst_ni(rst_n), .sync_i(sync_p), .div_int_i(12'd3), .div_frac_i(24'h0),
    .int_only_i(1'b1), .bypass_i(1'b0), .ssc_en_i(1'b0), .ssc_step_i(24'h0),
    .ssc_lim_i(24'h0), .ssc_hold_i(16'h0), .tick_o(tick_b));

  int     checks = 0, fails = 0;
  longint m_acc = 0, m_off = 0, m_hc = 0;
  bit     m_dn = 0, run_m = 0, last_t = 0, align_on = 0;
  int     exp_len = 0, elapsed = 0;
  string  exp_tag = "R1", tag_ovr = "";

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  // new period from the rules, using current inputs
  task automatic model_period(input bit from_sync);
    longint base_acc, base_off, total, q, hold_last;
    base_acc = from_sync ? 0 : m_acc;
    base_off = from_sync ? 0 : m_off;
    q = (dint == 0) ? 1 : longint'(dint);
    if (byp) begin
      exp_len = 1;
      m_acc = base_acc;
    end else if (iono) begin
      exp_len = int'(q);
      m_acc = base_acc;
    end else begin
      total = base_acc + longint'(dfrac) + (sen ? base_off : 0);
      exp_len = int'(q + (total >> 24));
      m_acc = total & 64'hFF_FFFF;
    end
    if (from_sync) exp_tag = "R5";
    else if (tag_ovr != "") exp_tag = tag_ovr;
    else if (byp) exp_tag = "R3";
    else if (iono) exp_tag = "R2";
    else if (dint == 0) exp_tag = "R4";
    else if (sen) exp_tag = "R8";
    else exp_tag = "R1";
    if (from_sync || !sen) begin
      m_off = 0; m_dn = 0; m_hc = 0;
    end else begin
      hold_last = (shold == 0) ? 0 : longint'(shold) - 1;
      if (m_hc >= hold_last) begin
        m_hc = 0;
        if (!m_dn) begin
          if (m_off + longint'(sstep) >= longint'(slim)) begin m_off = slim; m_dn = 1; end
          else m_off = m_off + sstep;
        end else begin
          if (m_off <= longint'(sstep)) begin m_off = 0; m_dn = 0; end
          else m_off = m_off - sstep;
        end
      end else m_hc++;
    end
    elapsed = 0;
  endtask

  task automatic step();
    if (sync_p) begin run_m = 1; model_period(1); end
    else if (run_m && last_t) model_period(0);
    @(negedge clk);
    if (run_m) elapsed++;
    last_t = tick;
    if (!run_m) chk(!tick, "R10", tick, 0);
    else if (tick || elapsed == exp_len)
      chk(tick && elapsed == exp_len, exp_tag, elapsed, exp_len);
    if (align_on && tick) chk(tick_b, "R6", tick_b, 1);
  endtask

  task automatic do_sync();
    sync_p = 1'b1; step(); sync_p = 1'b0;
  endtask

  task automatic run(input int n);
    repeat (n) step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    void'($urandom(32'd4242));
    // R10: quiet in reset and before first sync
    repeat (3) begin @(negedge clk); chk(!tick, "R10", tick, 0); end
    rst_n = 1'b1;
    @(negedge clk);
    dint = 12'd5; dfrac = 24'h400000;
    run(12);

    // R1: half fraction alternates lengths
    dint = 12'd4; dfrac = 24'h800000;
    do_sync(); run(80);
    // R1: odd fraction
    dfrac = 24'h555555; run(120);

    // R4: whole part zero
    dint = 12'd0; dfrac = 24'h000000; run(20);
    dfrac = 24'hC00000; run(40);

    // R2: fraction and spread ignored
    dint = 12'd3; dfrac = 24'hFFFFFF; iono = 1'b1; sen = 1'b1;
    sstep = 24'h800000; slim = 24'hFFFFFF; shold = 16'd1; run(60);
    iono = 1'b0; sen = 1'b0;

    // R3: pass-through wins over everything
    byp = 1'b1; iono = 1'b1; dint = 12'd7; run(30);
    byp = 1'b0; iono = 1'b0;

    // R8: triangle spread with clamping
    dint = 12'd3; dfrac = 24'h0; sen = 1'b1;
    sstep = 24'h400000; slim = 24'hA00000; shold = 16'd2;
    do_sync(); run(500);
    shold = 16'd0; sstep = 24'h300000; slim = 24'hF00000; run(400);

    // R9: disabling clears the offset
    tag_ovr = "R9"; sen = 1'b0; dfrac = 24'h100000; run(150);
    tag_ovr = "";

    // R6: shared sync aligns two instances
    iono = 1'b1; dint = 12'd6; align_on = 1'b1;
    do_sync(); run(90);
    align_on = 1'b0; iono = 1'b0;

    // R5: sync in mid-period restarts
    dint = 12'd9; dfrac = 24'h123456; run(5); do_sync(); run(40);

    // R7: inputs changing at random points inside periods
    tag_ovr = "R7";
    for (int i = 0; i < 6000; i++) begin
      if ($urandom_range(0, 3) == 0) begin
        dint  = 12'($urandom_range(0, 6));
        dfrac = 24'($urandom);
        byp   = ($urandom_range(0, 9) == 0);
        iono  = ($urandom_range(0, 5) == 0);
        sen   = 1'($urandom_range(0, 1));
        sstep = 24'($urandom_range(0, 24'hFFFFFF));
        slim  = 24'($urandom_range(0, 24'hFFFFFF));
        shold = 16'($urandom_range(0, 3));
      end
      sync_p = ($urandom_range(0, 59) == 0);
      step();
      sync_p = 1'b0;
    end
    tag_ovr = "";
    summary();
  end
endmodule